// File: doc/BRIEF.md
# Prescaled Update Timer

This block is an up-counting timer with a programmable clock divider in front of it. Each input clock either advances a divider; when the divider has seen its programmed number of clocks plus one, the main counter steps by one. When the main counter steps past its programmed limit, it returns to zero and an update event fires. The time between update events is therefore (divider setting + 1) × (limit + 1) input clocks.

Every update event sets a sticky flag. An enable register routes that flag to a level interrupt line. It can also turn each update event into a one-cycle DMA request pulse. Software reaches six registers over a plain single-cycle register bus: a write strobe, an address, write data and combinational read data. The enable register keeps fixed bit positions for per-channel compare and trigger enables that a wider timer would decode. Here those bits are stored and read back but drive nothing.

While the timer runs, new divider and limit values wait in holding registers and take effect at the next update event. While it is stopped, they take effect on the next clock. The register bus is a control path, so it has no valid/ready handshake and no back-pressure: every write is taken in the cycle its strobe is high.

Top module: `pscl_timer`

## Requirements
- R1: After reset the counter, status flag, run bit, enable register and divider value read 0, the limit reads all ones, and `irq_o` and `dma_req_o` are low.
- R2: While the run bit (control register bit 0) is 1, the counter advances by one every (divider + 1) clocks. While it is 0, the counter holds its value and the divider restarts from zero.
- R3: A count step taken while the counter equals the active limit loads 0 instead and is an update event. Update events repeat every (divider + 1) × (limit + 1) clocks.
- R4: An update event sets status bit 0. A status write with data bit 0 equal to 0 clears it, and a write with bit 0 equal to 1 leaves it unchanged. An update event in the same cycle as a clearing write leaves the flag set.
- R5: In the enable register, only bits 0–4, 6, 8–12 and 14 are stored. The other bits read 0.
- R6: `irq_o` is high exactly while status bit 0 and enable bit 0 are both 1.
- R7: `dma_req_o` is high for one cycle, in the cycle after each update event, when enable bit 8 is 1. It is never high otherwise.
- R8: Writes to the divider and limit registers read back at once. While running, they take effect only at the next update event. While stopped, they take effect one clock after the write.
- R9: The counter register reads the live count. A write to it loads the written value, and this takes priority over a count step or wrap in the same cycle.
- R10: Register addresses are: 0 control, 1 enable, 2 status, 3 divider, 4 limit, 5 counter. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one write per high cycle |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Update interrupt level |
| dma_req_o | output | 1 | Update DMA request pulse |

## Verification
The bench drives a clearing status write into the exact cycle of an update event. A design where software wins would drop the flag and lower `irq_o`. It rewrites the limit and divider while the timer runs and measures the spacing of DMA pulses. A design that applied the values at once would shorten the current period instead of the next one. It also loads the counter on a counting clock, where a design that lets the step win would read one higher. It then checks that stopping freezes the count and that the enable gating holds `irq_o` and `dma_req_o` low while the flag is set.

// File: rtl/pscl_timer_pkg.sv
package pscl_timer_pkg;
  localparam int ADDR_W = 3;
  localparam int IEN_W  = 16;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] A_DIV  = 3'd3;
  localparam logic [ADDR_W-1:0] A_LIM  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd5;

  localparam int UPD_IRQ_BIT = 0;
  localparam int UPD_DMA_BIT = 8;
  localparam int CHAN_N      = 4;
  localparam int TRIG_BIT    = 6;
  localparam int DMA_OFS     = 8;

  // interrupt enables in the low byte, matching DMA enables one byte up
  function automatic logic [IEN_W-1:0] ien_mask();
    logic [IEN_W-1:0] m;
    m = '0;
    for (int b = 0; b <= CHAN_N; b++) begin
      m[b]           = 1'b1;
      m[b + DMA_OFS] = 1'b1;
    end
    m[TRIG_BIT]           = 1'b1;
    m[TRIG_BIT + DMA_OFS] = 1'b1;
    return m;
  endfunction

  localparam logic [IEN_W-1:0] IEN_MASK = ien_mask();
endpackage

// File: rtl/pscl_divider.sv
module pscl_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] div_val,
  output logic         tick
);
  logic [W-1:0] pc;
  logic         at_end;

  assign at_end = (pc == div_val);
  assign tick   = run & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pc <= '0;
    else if (!run || at_end) pc <= '0;
    else                     pc <= pc + 1'b1;
  end

  // R2
  div_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pc == '0));
endmodule

// File: rtl/pscl_counter.sv
module pscl_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] lim,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic         upd
);
  assign upd = tick & (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (ld)   cnt <= ld_val;
    else if (upd)  cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  // R3
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !ld) |=> (cnt == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld) |=> $stable(cnt));

  // R9
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt == $past(ld_val)));
endmodule

// File: rtl/pscl_regs.sv
module pscl_regs
  import pscl_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic              upd,
  input  logic [W-1:0]      cnt,
  output logic              run,
  output logic [W-1:0]      div_act,
  output logic [W-1:0]      lim_act,
  output logic              cnt_ld,
  output logic [W-1:0]      cnt_ld_val,
  output logic              irq,
  output logic              dma_req
);
  logic [IEN_W-1:0] ien;
  logic             uif;
  logic [W-1:0]     div_sh;
  logic [W-1:0]     lim_sh;
  logic             wr_ctrl, wr_ien, wr_stat, wr_div, wr_lim;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_ien  = bus_wr && (bus_addr == A_IEN);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign wr_div  = bus_wr && (bus_addr == A_DIV);
  assign wr_lim  = bus_wr && (bus_addr == A_LIM);

  assign cnt_ld     = bus_wr && (bus_addr == A_CNT);
  assign cnt_ld_val = bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      ien     <= '0;
      uif     <= 1'b0;
      div_sh  <= '0;
      lim_sh  <= '1;
      div_act <= '0;
      lim_act <= '1;
      dma_req <= 1'b0;
    end else begin
      if (wr_ctrl) run    <= bus_wdata[0];
      if (wr_ien)  ien    <= bus_wdata[IEN_W-1:0] & IEN_MASK;
      if (wr_div)  div_sh <= bus_wdata;
      if (wr_lim)  lim_sh <= bus_wdata;
      if (upd)                            uif <= 1'b1;
      else if (wr_stat && !bus_wdata[0])  uif <= 1'b0;
      if (upd || !run) begin
        div_act <= div_sh;
        lim_act <= lim_sh;
      end
      dma_req <= upd & ien[UPD_DMA_BIT];
    end
  end

  assign irq = uif & ien[UPD_IRQ_BIT];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata[0] = run;
      A_IEN:   bus_rdata[IEN_W-1:0] = ien;
      A_STAT:  bus_rdata[0] = uif;
      A_DIV:   bus_rdata = div_sh;
      A_LIM:   bus_rdata = lim_sh;
      A_CNT:   bus_rdata = cnt;
      default: bus_rdata = '0;
    endcase
  end

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> uif);

  // R4
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !bus_wdata[0] && !upd) |=> !uif);

  // R7
  dma_after_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> $past(upd));

  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !upd) |=> ($stable(lim_act) && $stable(div_act)));
endmodule

// File: rtl/pscl_timer.sv
module pscl_timer
  import pscl_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic              irq_o,
  output logic              dma_req_o
);
  logic         run, tick, upd, cnt_ld;
  logic [W-1:0] div_act, lim_act, cnt, cnt_ld_val;

  pscl_divider #(.W(W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .div_val (div_act),
    .tick    (tick)
  );

  pscl_counter #(.W(W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .lim    (lim_act),
    .ld     (cnt_ld),
    .ld_val (cnt_ld_val),
    .cnt    (cnt),
    .upd    (upd)
  );

  pscl_regs #(.W(W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .upd        (upd),
    .cnt        (cnt),
    .run        (run),
    .div_act    (div_act),
    .lim_act    (lim_act),
    .cnt_ld     (cnt_ld),
    .cnt_ld_val (cnt_ld_val),
    .irq        (irq_o),
    .dma_req    (dma_req_o)
  );
endmodule

// File: tb/pscl_timer_tb.sv
module pscl_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        irq_o, dma_req_o;

  always #2.5 clk = ~clk;

  pscl_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .dma_req_o(dma_req_o)
  );

  int    total = 0;
  int    bad   = 0;
  int    cyc   = 0;
  bit    chk_on = 0;
  string cur_tag = "R1";

  // behavioural reference state
  logic        m_run = 0, m_uif = 0, m_dma = 0;
  logic [15:0] m_en = 0, m_dsh = 0, m_lsh = 16'hFFFF, m_da = 0, m_la = 16'hFFFF;
  logic [15:0] m_pc = 0, m_cnt = 0;
  bit          tk, up;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {15'b0, m_run};
      3'd1: return m_en;
      3'd2: return {15'b0, m_uif};
      3'd3: return m_dsh;
      3'd4: return m_lsh;
      3'd5: return m_cnt;
      default: return 16'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_run = 0; m_uif = 0; m_dma = 0; m_en = 0; m_dsh = 0; m_lsh = 16'hFFFF;
      m_da = 0; m_la = 16'hFFFF; m_pc = 0; m_cnt = 0;
    end else begin
      tk = m_run && (m_pc == m_da);
      up = tk && (m_cnt == m_la);
      m_pc = (m_run && !tk) ? m_pc + 16'd1 : 16'd0;
      if (bus_wr && bus_addr == 3'd5) m_cnt = bus_wdata;
      else if (up)                    m_cnt = 0;
      else if (tk)                    m_cnt = m_cnt + 16'd1;
      if (up) m_uif = 1;
      else if (bus_wr && bus_addr == 3'd2 && !bus_wdata[0]) m_uif = 0;
      m_dma = up && m_en[8];
      if (up || !m_run) begin m_da = m_dsh; m_la = m_lsh; end
      if (bus_wr && bus_addr == 3'd0) m_run = bus_wdata[0];
      if (bus_wr && bus_addr == 3'd1) m_en  = bus_wdata & 16'h5F5F;
      if (bus_wr && bus_addr == 3'd3) m_dsh = bus_wdata;
      if (bus_wr && bus_addr == 3'd4) m_lsh = bus_wdata;
    end
  end

  // per-cycle comparison, well away from the active edge
  always begin
    @(negedge clk);
    #2;
    if (chk_on) begin
      chk(irq_o === (m_uif & m_en[0]), "R6", {15'b0, irq_o}, {15'b0, m_uif & m_en[0]});
      chk(dma_req_o === m_dma, "R7", {15'b0, dma_req_o}, {15'b0, m_dma});
      chk(bus_rdata === m_read(bus_addr), cur_tag, bus_rdata, m_read(bus_addr));
    end
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    finish_run();
  end

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_addr = 3'd5;
  endtask

  task automatic wait_dma(output int at);
    do begin @(negedge clk); #2; end while (dma_req_o !== 1'b1);
    at = cyc;
  endtask

  initial begin
    int c1, c2;
    logic [15:0] held;
    rst_n = 0; bus_wr = 0; bus_addr = 3'd5; bus_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_on = 1;

    // R1 and R10: reset values on every address
    for (int a = 0; a < 8; a++) begin
      bus_addr = a[2:0];
      #2;
      chk(bus_rdata === ((a == 4) ? 16'hFFFF : 16'h0), (a > 5) ? "R10" : "R1",
          bus_rdata, (a == 4) ? 16'hFFFF : 16'h0);
      chk(irq_o === 0 && dma_req_o === 0, "R1", {14'b0, irq_o, dma_req_o}, 16'h0);
      @(negedge clk);
    end

    // R5: only the defined enable bits stick
    cur_tag = "R5";
    wr(3'd1, 16'hFFFF);
    bus_addr = 3'd1; #2;
    chk(bus_rdata === 16'h5F5F, "R5", bus_rdata, 16'h5F5F);
    @(negedge clk);
    wr(3'd1, 16'h0101);

    // R8: stopped, new values apply before start
    cur_tag = "R8";
    wr(3'd3, 16'd2);
    wr(3'd4, 16'd4);
    wr(3'd0, 16'd1);

    // R3: period (2+1)*(4+1) = 15
    cur_tag = "R3";
    wait_dma(c1);
    wait_dma(c2);
    chk((c2 - c1) == 15, "R3", 16'(c2 - c1), 16'd15);
    chk(irq_o === 1'b1, "R6", {15'b0, irq_o}, 16'd1);

    // R4: write 1 keeps, write 0 clears
    cur_tag = "R4";
    @(negedge clk);
    wr(3'd2, 16'h0001);
    bus_addr = 3'd2; #2;
    chk(bus_rdata[0] === 1'b1, "R4", bus_rdata, 16'h1);
    @(negedge clk);
    wr(3'd2, 16'hFFFE);
    bus_addr = 3'd2; #2;
    chk(bus_rdata[0] === 1'b0, "R4", bus_rdata, 16'h0);
    @(negedge clk);
    // R4: clear in the same cycle as an update event
    while (!(m_run && m_pc == m_da && m_cnt == m_la)) @(negedge clk);
    wr(3'd2, 16'h0000);
    bus_addr = 3'd2; #2;
    chk(bus_rdata[0] === 1'b1, "R4", bus_rdata, 16'h1);
    @(negedge clk);

    // R8: running, new period only after the next update
    cur_tag = "R8";
    bus_addr = 3'd5;
    wr(3'd4, 16'd1);
    wr(3'd3, 16'd0);
    wait_dma(c1);
    wait_dma(c1);
    wait_dma(c2);
    chk((c2 - c1) == 2, "R8", 16'(c2 - c1), 16'd2);

    // R9: counter load beats a counting clock
    cur_tag = "R9";
    @(negedge clk);
    wr(3'd4, 16'd9);
    wait_dma(c1);
    @(negedge clk);
    wr(3'd5, 16'd7);
    #2;
    chk(bus_rdata === 16'd7, "R9", bus_rdata, 16'd7);
    @(negedge clk);
    #2;
    chk(bus_rdata === 16'd8, "R9", bus_rdata, 16'd8);
    @(negedge clk);

    // R6 / R7 gating by the enable bits
    cur_tag = "R6";
    wr(3'd1, 16'h0100);
    repeat (25) @(negedge clk);
    #2;
    chk(irq_o === 1'b0, "R6", {15'b0, irq_o}, 16'h0);
    @(negedge clk);
    cur_tag = "R7";
    wr(3'd1, 16'h0001);
    repeat (25) @(negedge clk);
    #2;
    chk(irq_o === 1'b1, "R6", {15'b0, irq_o}, 16'h1);
    chk(dma_req_o === 1'b0, "R7", {15'b0, dma_req_o}, 16'h0);
    @(negedge clk);

    // R2: stopping freezes the count
    cur_tag = "R2";
    wr(3'd0, 16'd0);
    #2;
    held = bus_rdata;
    repeat (6) @(negedge clk);
    #2;
    chk(bus_rdata === held, "R2", bus_rdata, held);
    @(negedge clk);

    finish_run();
  end
endmodule